// File: doc/BRIEF.md
# Serial Programming Target

This block is the target end of a four-wire serial programming link. A host clocks four-byte instructions in on `mosi` with `sck` while holding `prog_n` low. The block decodes each complete instruction and applies it to two small on-chip arrays. The first array is a word-wide flash model, written page by page through a staging buffer. The second is a byte-wide EEPROM model. Reply bytes go back on `miso`.

All link inputs pass through two-flop synchronisers into the `clk` domain. `sck` edges are detected there, so each `sck` phase must last several `clk` cycles. Flash page commits and EEPROM writes keep the block busy for a parameterised number of `clk` cycles. While a page commit is running, reads inside that page return 0xFF. The host uses this to poll for completion.

Top module: `isp_target`

## Requirements
- R1: Every instruction is four bytes, sent MSB first. `mosi` is sampled on rising `sck`. The instruction takes effect when the 32nd bit has been received, and all four bytes must be clocked even when the link is not enabled.
- R2: `miso` changes only after a falling `sck` edge, or when `prog_n` is released. Each reply bit is steady for the whole high phase of `sck` that follows it. Reply bytes are sent MSB first.
- R3: During the third byte of every instruction, `miso` sends back the second byte that was received. The instruction 0xAC 0x53 xx xx enables the link.
- R4: Until the link is enabled, every instruction except the enable instruction is ignored. Its fourth reply byte is 0x00 and it writes nothing. Raising `prog_n` clears the enable and restarts byte and bit counting.
- R5: Buffer load low (0x40 xx AA DD) and buffer load high (0x48 xx AA DD) write DD into one half of staging word AA[PAGE_BITS-1:0]. The other half of that word keeps its previous value, which is 0xFF after reset.
- R6: Page commit (0x4C AH AL xx) copies the whole staging buffer into the flash page selected by bits [PAGE_BITS+PAGE_CNT_BITS-1:PAGE_BITS] of word address {AH,AL}. The block then stays busy for FLASH_BUSY cycles.
- R7: While a commit is busy, flash reads inside the committed page return 0xFF. Reads of other pages return stored data, and the committed data is returned once the busy time has ended.
- R8: Flash read low (0x20 AH AL xx) and flash read high (0x28 AH AL xx) return that byte of word {AH,AL} in reply byte four. Address bits above the array size are ignored. Instructions that are not reads reply 0x00 in byte four.
- R9: EEPROM write (0xC0 AH AL DD) stores DD at address AL[EE_ABITS-1:0]. The location reads 0xFF (erased) for EE_BUSY cycles and then reads DD.
- R10: EEPROM read (0xA0 AH AL xx) returns the addressed byte in reply byte four.
- R11: Chip erase (0xAC 0x80 xx xx) sets every flash byte and every EEPROM byte to 0xFF.
- R12: A chip erase, page commit or EEPROM write that completes while either array is busy is ignored.
- R13: After `rst_n`, `miso` is 0, the link is disabled, and every array location reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| prog_n | input | 1 | Active-low programming session; high clears the session |
| sck | input | 1 | Serial clock from the host, asynchronous |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial reply data to the host |

## Verification
Two functions can meet in the same cycle. The fourth-byte read reply is loaded in the same cycle that the commit busy window is being evaluated against the read address. The bench provokes this by issuing flash reads right after a page commit. The first read goes to another page, the second to the committed page while still busy, and the third to the committed page after the window. It expects stored data, then 0xFF, then the new data. The second overlap is a write that finishes while the other array is busy. The bench sends an EEPROM write right behind a page commit and judges it by reading that EEPROM location once the block is idle.

// File: rtl/isp_pkg.sv
// Shared constants for the serial programming target.
// Assumes a byte-wide serial frame of a fixed number of bytes.
package isp_pkg;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 4;
    localparam int BITCNT_W    = $clog2(BYTE_W);
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    typedef enum logic [7:0] {
        OP_SESSION = 8'hAC,
        OP_BUF_LO  = 8'h40,
        OP_BUF_HI  = 8'h48,
        OP_COMMIT  = 8'h4C,
        OP_FRD_LO  = 8'h20,
        OP_FRD_HI  = 8'h28,
        OP_EE_WR   = 8'hC0,
        OP_EE_RD   = 8'hA0
    } isp_op_e;

    localparam logic [7:0] KEY_ENABLE = 8'h53;
    localparam logic [7:0] KEY_ERASE  = 8'h80;
endpackage

// File: rtl/isp_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous inputs.
// Assumes each bit is sampled on its own; no bus coherency is implied.
module isp_sync #(
    parameter int              WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/isp_shifter.sv
// Serial byte engine: detects sck edges on synchronised inputs, assembles
// MSB-first bytes on rising edges and shifts reply bits on falling edges.
// Assumes sck phases last at least three clk cycles.
module isp_shifter
    import isp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sck_s,
    input  logic             mosi_s,
    input  logic [BYTE_W-1:0] tx_next,
    output logic             byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic [IDX_W-1:0] byte_idx,
    output logic             sck_fall,
    output logic             miso
);
    logic                sck_d;
    logic                sck_rise;
    logic [BYTE_W-1:0]   rx;
    logic [BYTE_W-1:0]   tx;
    logic [BYTE_W-1:0]   tx_pend;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [IDX_W-1:0]    idx;

    assign sck_rise  = sck_s & ~sck_d;
    assign sck_fall  = ~sck_s & sck_d;
    assign byte_val  = {rx[BYTE_W-2:0], mosi_s};
    assign byte_done = sck_rise && (bit_cnt == BITCNT_W'(BYTE_W - 1));
    assign byte_idx  = idx;
    assign miso      = tx[BYTE_W-1];

    // Delayed copy of sck for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end

    // Receive on rising edges, load or shift the reply on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rx      <= '0;
            tx      <= '0;
            tx_pend <= '0;
            bit_cnt <= '0;
            idx     <= '0;
        end else begin
            if (sck_rise) begin
                rx      <= byte_val;
                bit_cnt <= bit_cnt + 1'b1;
                if (byte_done) begin
                    idx     <= idx + 1'b1;
                    tx_pend <= tx_next;
                end
            end
            if (sck_fall) begin
                if (bit_cnt == '0) tx <= tx_pend;
                else               tx <= {tx[BYTE_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/isp_mem.sv
// Memory model: word flash with split-half staging buffer, byte EEPROM,
// busy timers and the read mux that masks a page under commit.
// Assumes exec pulses for one cycle per completed instruction.
module isp_mem
    import isp_pkg::*;
#(
    parameter int PAGE_BITS     = 3,
    parameter int PAGE_CNT_BITS = 2,
    parameter int EE_ABITS      = 4,
    parameter int FLASH_BUSY    = 900,
    parameter int EE_BUSY       = 900
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        exec,
    input  logic        enabled,
    input  logic [7:0]  op,
    input  logic [7:0]  a_hi,
    input  logic [7:0]  a_lo,
    input  logic [7:0]  data,
    input  logic [7:0]  rd_op,
    input  logic [7:0]  rd_hi,
    input  logic [7:0]  rd_lo,
    output logic [7:0]  rd_data,
    output logic        flash_busy,
    output logic        ee_busy
);
    localparam int FA    = PAGE_BITS + PAGE_CNT_BITS;
    localparam int PW    = 1 << PAGE_BITS;
    localparam int FW    = 1 << FA;
    localparam int EW    = 1 << EE_ABITS;
    localparam int FCW   = $clog2(FLASH_BUSY + 1);
    localparam int ECW   = $clog2(EE_BUSY + 1);

    logic [15:0] flash [FW];
    logic [7:0]  buf_lo [PW];
    logic [7:0]  buf_hi [PW];
    logic [7:0]  ee [EW];

    logic [15:0]              wr_full, rd_full;
    logic [FA-1:0]            wa, ra;
    logic [PAGE_CNT_BITS-1:0] busy_pg;
    logic [EE_ABITS-1:0]      busy_ea;
    logic [FCW-1:0]           fcnt;
    logic [ECW-1:0]           ecnt;
    logic                     unused_addr_bits;
    logic do_ce, do_pw, do_ew, do_ll, do_lh, idle;

    assign wr_full = {a_hi, a_lo};
    assign rd_full = {rd_hi, rd_lo};
    assign wa      = wr_full[FA-1:0];
    assign ra      = rd_full[FA-1:0];
    assign unused_addr_bits = ^{wr_full, rd_full};

    assign flash_busy = (fcnt != '0);
    assign ee_busy    = (ecnt != '0);
    assign idle       = !flash_busy && !ee_busy;

    // Command decode, qualified by session enable and busy state.
    assign do_ce = exec && enabled && idle && op == OP_SESSION && a_hi == KEY_ERASE;
    assign do_pw = exec && enabled && idle && op == OP_COMMIT;
    assign do_ew = exec && enabled && idle && op == OP_EE_WR;
    assign do_ll = exec && enabled && op == OP_BUF_LO;
    assign do_lh = exec && enabled && op == OP_BUF_HI;

    // Staging buffer halves, written independently.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < PW; w++) begin
                buf_lo[w] <= 8'hFF;
                buf_hi[w] <= 8'hFF;
            end
        end else if (do_ll) begin
            buf_lo[wa[PAGE_BITS-1:0]] <= data;
        end else if (do_lh) begin
            buf_hi[wa[PAGE_BITS-1:0]] <= data;
        end
    end

    // Flash array: erase or whole-page commit from the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || do_ce) begin
            for (int i = 0; i < FW; i++) flash[i] <= 16'hFFFF;
        end else if (do_pw) begin
            for (int w = 0; w < PW; w++)
                flash[{wa[FA-1:PAGE_BITS], PAGE_BITS'(w)}] <= {buf_hi[w], buf_lo[w]};
        end
    end

    // EEPROM array: erase or single byte write.
    always_ff @(posedge clk) begin
        if (!rst_n || do_ce) begin
            for (int i = 0; i < EW; i++) ee[i] <= 8'hFF;
        end else if (do_ew) begin
            ee[wr_full[EE_ABITS-1:0]] <= data;
        end
    end

    // Busy timers and the location each one guards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fcnt    <= '0;
            ecnt    <= '0;
            busy_pg <= '0;
            busy_ea <= '0;
        end else begin
            if (do_pw) begin
                fcnt    <= FCW'(FLASH_BUSY);
                busy_pg <= wa[FA-1:PAGE_BITS];
            end else if (flash_busy) begin
                fcnt <= fcnt - 1'b1;
            end
            if (do_ew) begin
                ecnt    <= ECW'(EE_BUSY);
                busy_ea <= wr_full[EE_ABITS-1:0];
            end else if (ee_busy) begin
                ecnt <= ecnt - 1'b1;
            end
        end
    end

    // Read mux with erased value shown for locations under write.
    always_comb begin
        case (rd_op)
            OP_FRD_LO: rd_data = (flash_busy && ra[FA-1:PAGE_BITS] == busy_pg) ? 8'hFF : flash[ra][7:0];
            OP_FRD_HI: rd_data = (flash_busy && ra[FA-1:PAGE_BITS] == busy_pg) ? 8'hFF : flash[ra][15:8];
            OP_EE_RD:  rd_data = (ee_busy && rd_full[EE_ABITS-1:0] == busy_ea) ? 8'hFF
                                                                              : ee[rd_full[EE_ABITS-1:0]];
            default:   rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/isp_target.sv
// Top of the serial programming target: synchronises the link, frames
// four-byte instructions, holds the session enable and builds replies.
// Assumes sck phases of at least three clk cycles.
module isp_target
    import isp_pkg::*;
#(
    parameter int PAGE_BITS     = 3,
    parameter int PAGE_CNT_BITS = 2,
    parameter int EE_ABITS      = 4,
    parameter int FLASH_BUSY    = 900,
    parameter int EE_BUSY       = 900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_n,
    input  logic sck,
    input  logic mosi,
    output logic miso
);
    logic             clr, sck_s, mosi_s, sck_fall;
    logic             byte_done, exec, enabled;
    logic [IDX_W-1:0] byte_idx;
    logic [7:0]       byte_val, tx_next, rd_data;
    logic [7:0]       op_q, hi_q, lo_q;
    logic             flash_busy, ee_busy;

    isp_sync #(.WIDTH(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({prog_n, sck, mosi}), .q({clr, sck_s, mosi_s})
    );

    isp_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr), .sck_s(sck_s), .mosi_s(mosi_s),
        .tx_next(tx_next), .byte_done(byte_done), .byte_val(byte_val),
        .byte_idx(byte_idx), .sck_fall(sck_fall), .miso(miso)
    );

    assign exec = byte_done && !clr && (byte_idx == IDX_W'(FRAME_BYTES - 1));

    // Frame field capture and session enable.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            op_q    <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            enabled <= 1'b0;
        end else if (byte_done) begin
            case (byte_idx)
                2'd0:    op_q <= byte_val;
                2'd1:    hi_q <= byte_val;
                2'd2:    lo_q <= byte_val;
                default: if (op_q == OP_SESSION && hi_q == KEY_ENABLE) enabled <= 1'b1;
            endcase
        end
    end

    // Reply byte for the next frame slot: echo in slot three, read data in four.
    always_comb begin
        case (byte_idx)
            2'd1:    tx_next = byte_val;
            2'd2:    tx_next = enabled ? rd_data : 8'h00;
            default: tx_next = 8'h00;
        endcase
    end

    isp_mem #(
        .PAGE_BITS(PAGE_BITS), .PAGE_CNT_BITS(PAGE_CNT_BITS), .EE_ABITS(EE_ABITS),
        .FLASH_BUSY(FLASH_BUSY), .EE_BUSY(EE_BUSY)
    ) u_mem (
        .clk(clk), .rst_n(rst_n), .exec(exec), .enabled(enabled),
        .op(op_q), .a_hi(hi_q), .a_lo(lo_q), .data(byte_val),
        .rd_op(op_q), .rd_hi(hi_q), .rd_lo(byte_val), .rd_data(rd_data),
        .flash_busy(flash_busy), .ee_busy(ee_busy)
    );
endmodule

// File: rtl/isp_target_chk.sv
// Protocol checker for isp_target, attached by bind.
// Assumes it observes the top's internal framing and busy signals.
module isp_target_chk (
    input logic clk,
    input logic rst_n,
    input logic clr,
    input logic sck_fall,
    input logic miso,
    input logic exec,
    input logic enabled,
    input logic flash_busy,
    input logic ee_busy
);
    p_miso_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miso) |-> ($past(sck_fall) || $past(clr)));

    p_enable_at_frame_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enabled) |-> $past(exec));

    p_release_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !enabled);

    p_commit_starts_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_busy) |-> $past(exec && enabled));

    p_ee_write_starts_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_busy) |-> $past(exec && enabled && !flash_busy));
endmodule

bind isp_target isp_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sck_fall(sck_fall), .miso(miso),
    .exec(exec), .enabled(enabled), .flash_busy(flash_busy), .ee_busy(ee_busy)
);

// File: tb/sim_isp_target.sv
// Bench for isp_target: a vector table walked by one loop, then directed
// tests for busy windows, erase, session release and reset.
module sim_isp_target;
    localparam int HALF  = 6;
    localparam int QUIET = 1200;

    typedef struct packed {
        logic [31:0] ins;
        logic [7:0]  e3;
        logic [7:0]  e4;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{32'h2000_0000, 8'h00, 8'h00},  // R4: read before enable gives 0x00
        '{32'hAC53_0000, 8'h53, 8'h00},  // R3: enable, key echoed
        '{32'h2000_0500, 8'h00, 8'hFF},  // R8 R13: erased flash
        '{32'hA000_0300, 8'h00, 8'hFF},  // R10 R13: erased EEPROM
        '{32'h4000_0234, 8'h00, 8'h00},  // R5: load low word 2
        '{32'h4800_0212, 8'h00, 8'h00},  // R5: load high word 2
        '{32'h4000_03CD, 8'h00, 8'h00}   // R5: load low word 3 only
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;
    int   n_chk = 0;
    int   n_err = 0;
    int   glitch = 0;
    logic [7:0] r3, r4, rb;

    always #4 clk = ~clk;

    isp_target u0 (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            mosi = b[i];
            repeat (HALF) @(negedge clk);
            r[i] = miso;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            if (miso !== r[i]) glitch++;
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [31:0] ins, output logic [7:0] o3, output logic [7:0] o4);
        logic [7:0] r;
        xbyte(ins[31:24], r);
        xbyte(ins[23:16], r);
        xbyte(ins[15:8], o3);
        xbyte(ins[7:0], o4);
    endtask

    task automatic session(input logic high);
        prog_n = high;
        repeat (20) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R13 MISO after reset", {7'b0, miso}, 8'h00);
        session(1'b0);

        // R1 R4: a partial frame is dropped by releasing the session
        xbyte(8'hAA, rb);
        xbyte(8'h55, rb);
        session(1'b1);
        session(1'b0);

        for (int v = 0; v < NV; v++) begin
            xfer(VEC[v].ins, r3, r4);
            check($sformatf("R1 R3 vector %0d echo", v), r3, VEC[v].e3);
            check($sformatf("R8 vector %0d reply", v), r4, VEC[v].e4);
        end

        // R6: commit buffer to page 0, then read it back idle
        xfer(32'h4C00_0000, r3, r4);
        repeat (QUIET) @(negedge clk);
        xfer(32'h2000_0200, r3, r4); check("R6 word 2 low", r4, 8'h34);
        xfer(32'h2800_0200, r3, r4); check("R5 word 2 high", r4, 8'h12);
        xfer(32'h2800_0300, r3, r4); check("R5 word 3 high untouched", r4, 8'hFF);
        xfer(32'h2000_0300, r3, r4); check("R6 word 3 low", r4, 8'hCD);
        xfer(32'h20FF_E200, r3, r4); check("R8 upper address ignored", r4, 8'h34);

        // R7: commit page 1, poll other page, same page busy, same page done
        xfer(32'h4000_0277, r3, r4);
        xfer(32'h4C00_0800, r3, r4);
        xfer(32'h2000_0200, r3, r4); check("R7 other page during busy", r4, 8'h34);
        xfer(32'h2000_0A00, r3, r4); check("R7 busy page masked", r4, 8'hFF);
        xfer(32'h2000_0A00, r3, r4); check("R7 busy page after", r4, 8'h77);
        xfer(32'h2000_0B00, r3, r4); check("R6 whole page copied", r4, 8'hCD);

        // R9: EEPROM location reads erased while busy, then the data
        xfer(32'hC000_045A, r3, r4);
        xfer(32'hA000_0400, r3, r4); check("R9 EEPROM erased while busy", r4, 8'hFF);
        xfer(32'hA000_0400, r3, r4);
        xfer(32'hA000_0400, r3, r4); check("R9 R10 EEPROM written", r4, 8'h5A);

        // R12: EEPROM write behind a commit is dropped
        xfer(32'h4C00_0000, r3, r4);
        xfer(32'hC000_06AA, r3, r4);
        repeat (QUIET) @(negedge clk);
        xfer(32'hA000_0600, r3, r4); check("R12 write during busy ignored", r4, 8'hFF);

        // R11: chip erase clears both arrays
        xfer(32'hAC80_0000, r3, r4);
        xfer(32'h2000_0200, r3, r4); check("R11 flash erased", r4, 8'hFF);
        xfer(32'hA000_0400, r3, r4); check("R11 EEPROM erased", r4, 8'hFF);

        // R4: session release disables; writes before re-enable are ignored
        session(1'b1);
        session(1'b0);
        xfer(32'hC000_0611, r3, r4);
        xfer(32'hA000_0600, r3, r4); check("R4 read while disabled", r4, 8'h00);
        xfer(32'hAC53_0000, r3, r4); check("R3 echo on re-enable", r3, 8'h53);
        repeat (QUIET) @(negedge clk);
        xfer(32'hA000_0600, r3, r4); check("R4 disabled write ignored", r4, 8'hFF);

        check("R2 MISO steady while SCK high", 8'(glitch), 8'h00);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule